// File: doc/BRIEF.md
# Multichannel UART interrupt context unit

This block sits between eight UART channels and a host. Each channel raises a request when its receive FIFO holds data, when its transmit FIFO has room, or when one of its status events (change of state, address match, flow-control status, break change) fires. On a dedicated update strobe from the host, the block latches the lowest-numbered channel that is requesting. It also takes a snapshot of that channel's interrupt type and byte count at the same edge.

The host then reads a channel register, a type register and a count register, all for the latched channel. A single data address moves bytes between the host and that channel's FIFOs. A read of the data address returns the channel's receive FIFO head byte, with the bits above the character length cleared, and pops that FIFO. A write to the data address pushes the byte into the channel's transmit FIFO. The host therefore serves any channel through one fixed set of addresses. The FIFOs, the serial engines and the event sources are outside the block.

Address map on `addr_i`: 0 is the channel register, 1 is the type register, 2 is the count register, and 3 is the data port. Register reads are combinational.

Top module: `uart_irq_ctx`

## Requirements
- R1: After reset, the channel, type and count registers all read 0x00.
- R2: On a cycle with `upd_i` high, the lowest-numbered channel that has a pending request is latched. The latched channel changes only on an update.
- R3: The channel register reads bit 7 = 1 when the last update found a pending request, and bits 2:0 = the latched channel. All other bits are 0. If the update found no request, the register reads 0x00.
- R4: Type bits 7:6 read 11 for a receive request without error, 10 for a receive request with the error flag set, and 00 when the channel has no receive request.
- R5: Type bit 5 is 1 for a transmit request. When a channel has a receive request and a transmit request together, bits 7:6 report the receive request and bit 5 reads 0.
- R6: Type bits 2:0 carry the channel's 3-bit event code, where 000 means none, 001 change of state, 010 address match, 011 flow-control status and 101 break change. Type bits 4:3 read 00.
- R7: The count register reads the number of bytes minus one in bits 3:0, with bits 7:4 at 0. The number is the receive fill level for a receive request and the transmit free space for a transmit request. So 1 byte reads 0x00 and 16 bytes read 0x0F.
- R8: A read of the data address returns the latched channel's receive head byte ANDed with a length mask. The channel's 2-bit length code selects the mask: 00 gives 5 bits, 01 gives 6 bits, 10 gives 7 bits, and 11 gives 8 bits. In the same cycle, the read pulses only that channel's `rx_pop_o` bit.
- R9: A write to the data address pulses only the latched channel's `tx_push_o` bit, with `tx_data_o` equal to `wdata_i`. This holds even when the latched interrupt is not a transmit request.
- R10: `irq_o` is high whenever any channel has a receive, transmit or event request.
- R11: The type and count registers keep their snapshot while the channel inputs change, until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_i | input | 1 | Host strobe that latches a new interrupt context |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| rx_rdy_i | input | 8 | Per-channel receive data ready |
| tx_rdy_i | input | 8 | Per-channel transmit space ready |
| rx_err_i | input | 8 | Per-channel receive error flag |
| rx_lvl_i | input | 40 | Per-channel receive fill level, 5 bits each |
| tx_free_i | input | 40 | Per-channel transmit free space, 5 bits each |
| evt_i | input | 24 | Per-channel event code, 3 bits each |
| char_len_i | input | 16 | Per-channel length code, 2 bits each |
| rx_data_i | input | 64 | Per-channel receive head byte, 8 bits each |
| rx_pop_o | output | 8 | Receive FIFO pop, one bit per channel |
| tx_push_o | output | 8 | Transmit FIFO push, one bit per channel |
| tx_data_o | output | 8 | Byte pushed into the transmit FIFO |
| irq_o | output | 1 | Any channel requesting |

## Verification
The assertions assume the following about the channel inputs:
- Every channel presents only legal event codes; 11x never appears.
- A channel that asserts receive ready reports a fill level of at least one.
- The host never asserts read and write in the same cycle.

The stimulus respects these limits:
- The stub channel models change only on falling clock edges.
- Event codes are drawn only from the defined set.
- Host reads, writes and update strobes are issued one at a time, each in its own cycle.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int DW    = 8;
  localparam int EVT_W = 3;
  localparam int LEN_W = 2;

  localparam logic [1:0] A_CIR  = 2'd0;
  localparam logic [1:0] A_TYPE = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  // length code 0..3 -> 5..8 data bits
  function automatic logic [DW-1:0] len_mask(input logic [LEN_W-1:0] c);
    return 8'hFF >> (2'd3 - c);
  endfunction
endpackage

// File: rtl/uic_arbiter.sv
module uic_arbiter #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [NCH-1:0]  req_i,
  output logic [CH_W-1:0] nxt_o,
  output logic [CH_W-1:0] ch_o,
  output logic            vld_o
);
  always_comb begin
    nxt_o = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (req_i[i]) nxt_o = CH_W'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_o  <= '0;
      vld_o <= 1'b0;
    end else if (upd_i) begin
      ch_o  <= nxt_o;
      vld_o <= |req_i;
    end
  end

  logic [NCH-1:0] below_w;
  assign below_w = (NCH'(1) << ch_o) - NCH'(1);

  assert_pick_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && |req_i) |=> (vld_o && (($past(req_i) & below_w) == '0) && $past(req_i[nxt_o])));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(ch_o) && $stable(vld_o)));
endmodule

// File: rtl/uic_ctx_snap.sv
module uic_ctx_snap #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1),
  parameter int CNT_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             rx_rdy_i,
  input  logic             rx_err_i,
  input  logic             tx_rdy_i,
  input  logic [2:0]       evt_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic [LVL_W-1:0] tx_free_i,
  output logic [7:0]       typ_o,
  output logic [7:0]       cnt_o
);
  logic [7:0]       typ_d;
  logic [CNT_W-1:0] cnt_d;
  logic [LVL_W-1:0] bytes;

  always_comb begin
    typ_d      = '0;
    typ_d[2:0] = evt_i;
    if (rx_rdy_i)      typ_d[7:6] = rx_err_i ? 2'b10 : 2'b11;
    else if (tx_rdy_i) typ_d[5]   = 1'b1;
  end

  always_comb begin
    if (rx_rdy_i)      bytes = rx_lvl_i;
    else if (tx_rdy_i) bytes = tx_free_i;
    else               bytes = '0;
    cnt_d = (bytes == '0) ? '0 : CNT_W'(bytes - LVL_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      typ_o <= '0;
      cnt_o <= '0;
    end else if (upd_i) begin
      typ_o <= typ_d;
      cnt_o <= 8'(cnt_d);
    end
  end

  assert_rx_over_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && rx_rdy_i && tx_rdy_i) |=> (typ_o[7] && !typ_o[5]));

  assert_other_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    typ_o[2:1] != 2'b11);

  assert_snap_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> ($stable(typ_o) && $stable(cnt_o)));
endmodule

// File: rtl/uic_host_port.sv
module uic_host_port
  import uic_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic [1:0]       addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic             vld_i,
  input  logic [7:0]       typ_i,
  input  logic [7:0]       cnt_i,
  input  logic [DW-1:0]    rx_head_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NCH-1:0]   rx_pop_o,
  output logic [NCH-1:0]   tx_push_o,
  output logic [DW-1:0]    tx_data_o
);
  logic [DW-1:0]  cir_w;
  logic [NCH-1:0] ch_oh;

  always_comb begin
    cir_w           = '0;
    cir_w[DW-1]     = vld_i;
    cir_w[CH_W-1:0] = ch_i;
  end

  assign ch_oh = NCH'(1) << ch_i;

  always_comb begin
    unique case (addr_i)
      A_CIR:   rdata_o = cir_w;
      A_TYPE:  rdata_o = typ_i;
      A_CNT:   rdata_o = cnt_i;
      default: rdata_o = rx_head_i & len_mask(len_i);
    endcase
  end

  assign rx_pop_o  = (rd_i && addr_i == A_DATA) ? ch_oh : '0;
  assign tx_push_o = (wr_i && addr_i == A_DATA) ? ch_oh : '0;
  assign tx_data_o = wdata_i;
endmodule

// File: rtl/uart_irq_ctx.sv
module uart_irq_ctx
  import uic_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 upd_i,
  input  logic [1:0]           addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  input  logic [NCH-1:0]       rx_rdy_i,
  input  logic [NCH-1:0]       tx_rdy_i,
  input  logic [NCH-1:0]       rx_err_i,
  input  logic [NCH*LVL_W-1:0] rx_lvl_i,
  input  logic [NCH*LVL_W-1:0] tx_free_i,
  input  logic [NCH*3-1:0]     evt_i,
  input  logic [NCH*2-1:0]     char_len_i,
  input  logic [NCH*8-1:0]     rx_data_i,
  output logic [NCH-1:0]       rx_pop_o,
  output logic [NCH-1:0]       tx_push_o,
  output logic [7:0]           tx_data_o,
  output logic                 irq_o
);
  localparam int CH_W = $clog2(NCH);

  logic [NCH-1:0]  req;
  logic [CH_W-1:0] nxt, ch_q;
  logic            vld_q;
  logic [7:0]      typ_q, cnt_q;

  for (genvar g = 0; g < NCH; g++) begin : g_req
    assign req[g] = rx_rdy_i[g] | tx_rdy_i[g] | (|evt_i[g*EVT_W +: EVT_W]);
  end

  assign irq_o = |req;

  uic_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .req_i(req),
    .nxt_o(nxt), .ch_o(ch_q), .vld_o(vld_q)
  );

  uic_ctx_snap #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_snap (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i),
    .rx_rdy_i(rx_rdy_i[nxt]), .rx_err_i(rx_err_i[nxt]), .tx_rdy_i(tx_rdy_i[nxt]),
    .evt_i(evt_i[nxt*EVT_W +: EVT_W]),
    .rx_lvl_i(rx_lvl_i[nxt*LVL_W +: LVL_W]),
    .tx_free_i(tx_free_i[nxt*LVL_W +: LVL_W]),
    .typ_o(typ_q), .cnt_o(cnt_q)
  );

  uic_host_port #(.NCH(NCH), .CH_W(CH_W)) u_host (
    .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .ch_i(ch_q), .vld_i(vld_q), .typ_i(typ_q), .cnt_i(cnt_q),
    .rx_head_i(rx_data_i[ch_q*DW +: DW]),
    .len_i(char_len_i[ch_q*LEN_W +: LEN_W]),
    .rdata_o(rdata_o), .rx_pop_o(rx_pop_o), .tx_push_o(tx_push_o), .tx_data_o(tx_data_o)
  );

  assert_one_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_pop_o) && (!rd_i || rx_pop_o == '0 || tx_push_o == '0));

  assert_one_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_push_o) && (tx_push_o == '0 || tx_data_o == wdata_i));

  assert_valid_tracks_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (vld_q == $past(irq_o)));
endmodule

// File: tb/tb_uart_irq_ctx.sv
module tb_uart_irq_ctx;
  localparam int NCH = 8;
  localparam int LW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       upd = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, tx_data;
  logic [NCH-1:0] rx_pop, tx_push;
  logic irq;

  logic [NCH-1:0] s_rx = 0, s_tx = 0, s_err = 0;
  logic [LW-1:0]  s_lvl [NCH];
  logic [LW-1:0]  s_free[NCH];
  logic [2:0]     s_evt [NCH];
  logic [1:0]     s_len [NCH];
  logic [7:0]     s_dat [NCH];

  logic [NCH*LW-1:0] p_lvl, p_free;
  logic [NCH*3-1:0]  p_evt;
  logic [NCH*2-1:0]  p_len;
  logic [NCH*8-1:0]  p_dat;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      p_lvl[i*LW +: LW]  = s_lvl[i];
      p_free[i*LW +: LW] = s_free[i];
      p_evt[i*3 +: 3]    = s_evt[i];
      p_len[i*2 +: 2]    = s_len[i];
      p_dat[i*8 +: 8]    = s_dat[i];
    end
  end

  uart_irq_ctx dut (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_rdy_i(s_rx), .tx_rdy_i(s_tx), .rx_err_i(s_err),
    .rx_lvl_i(p_lvl), .tx_free_i(p_free), .evt_i(p_evt), .char_len_i(p_len),
    .rx_data_i(p_dat), .rx_pop_o(rx_pop), .tx_push_o(tx_push), .tx_data_o(tx_data),
    .irq_o(irq)
  );

  int vectors = 0, miscompares = 0;

  // {is_wr, exp_data, exp_pop, exp_push}
  logic [24:0] exp_q[$];
  string       tag_q[$];

  task automatic host_rd(input logic [1:0] a, input logic [7:0] e, input logic [7:0] pop, input string tag);
    @(negedge clk);
    exp_q.push_back({1'b0, e, pop, 8'h00});
    tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] d, input logic [7:0] push, input string tag);
    @(negedge clk);
    exp_q.push_back({1'b1, d, 8'h00, push});
    tag_q.push_back(tag);
    addr = 2'd3; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #5;
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s irq_o act=%0b exp=%0b", tag, irq, e);
    end
  endtask

  // monitor: scoreboard pop and compare mid low phase
  always @(negedge clk) begin
    #5;
    if (rd || wr) begin
      logic [24:0] it;
      string t;
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard empty act=%02h exp=none", rdata);
      end else begin
        it = exp_q.pop_front();
        t  = tag_q.pop_front();
        if (!it[24] && rdata !== it[23:16]) begin
          miscompares++;
          $display("FAIL %s rdata act=%02h exp=%02h", t, rdata, it[23:16]);
        end
        if (rx_pop !== it[15:8]) begin
          miscompares++;
          $display("FAIL %s rx_pop act=%02h exp=%02h", t, rx_pop, it[15:8]);
        end
        if (tx_push !== it[7:0]) begin
          miscompares++;
          $display("FAIL %s tx_push act=%02h exp=%02h", t, tx_push, it[7:0]);
        end
        if (it[24] && tx_data !== it[23:16]) begin
          miscompares++;
          $display("FAIL %s tx_data act=%02h exp=%02h", t, tx_data, it[23:16]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      s_lvl[i] = 0; s_free[i] = 0; s_evt[i] = 0; s_len[i] = 2'd3; s_dat[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    host_rd(2'd0, 8'h00, 8'h00, "R1 cir");
    host_rd(2'd1, 8'h00, 8'h00, "R1 type");
    host_rd(2'd2, 8'h00, 8'h00, "R1 cnt");
    chk_irq(1'b0, "R10 idle");

    // two channels requesting: lowest wins
    @(negedge clk);
    s_rx[0] = 1; s_lvl[0] = 1;
    s_rx[3] = 1; s_lvl[3] = 4; s_err[3] = 1;
    chk_irq(1'b1, "R10 active");
    host_rd(2'd0, 8'h00, 8'h00, "R2 no update yet");
    do_upd();
    host_rd(2'd0, 8'h80, 8'h00, "R2 R3 lowest ch0");
    host_rd(2'd1, 8'hC0, 8'h00, "R4 rx no error");
    host_rd(2'd2, 8'h00, 8'h00, "R7 one byte");

    @(negedge clk);
    s_rx[0] = 0; s_lvl[0] = 0;
    do_upd();
    host_rd(2'd0, 8'h83, 8'h00, "R2 ch3");
    host_rd(2'd1, 8'h80, 8'h00, "R4 rx with error");
    host_rd(2'd2, 8'h03, 8'h00, "R7 four bytes");

    @(negedge clk);
    s_rx[3] = 0; s_lvl[3] = 0; s_err[3] = 0;
    s_tx[2] = 1; s_free[2] = 16;
    s_rx[5] = 1; s_lvl[5] = 3; s_dat[5] = 8'hFF; s_len[5] = 2'd1;
    do_upd();
    host_rd(2'd0, 8'h82, 8'h00, "R2 ch2");
    host_rd(2'd1, 8'h20, 8'h00, "R5 tx type");
    host_rd(2'd2, 8'h0F, 8'h00, "R7 sixteen free");

    @(negedge clk);
    s_tx[2] = 0; s_free[2] = 0;
    host_rd(2'd1, 8'h20, 8'h00, "R11 type held");
    host_rd(2'd2, 8'h0F, 8'h00, "R11 count held");
    do_upd();
    host_rd(2'd0, 8'h85, 8'h00, "R3 ch5");
    host_rd(2'd1, 8'hC0, 8'h00, "R4 ch5 rx");
    host_rd(2'd2, 8'h02, 8'h00, "R7 three bytes");
    host_rd(2'd3, 8'h3F, 8'h20, "R8 six bit data");

    @(negedge clk);
    s_err[5] = 1; s_tx[5] = 1; s_free[5] = 1; s_evt[5] = 3'b001;
    host_rd(2'd1, 8'hC0, 8'h00, "R11 type ignores inputs");
    do_upd();
    host_rd(2'd1, 8'h81, 8'h00, "R5 R6 rx over tx with event");
    host_rd(2'd2, 8'h02, 8'h00, "R7 rx count wins");

    @(negedge clk);
    s_rx[5] = 0; s_err[5] = 0; s_lvl[5] = 0;
    do_upd();
    host_rd(2'd1, 8'h21, 8'h00, "R5 R6 tx with event");
    host_rd(2'd2, 8'h00, 8'h00, "R7 one free");

    @(negedge clk);
    s_tx[5] = 0; s_free[5] = 0; s_evt[5] = 0;
    s_evt[7] = 3'b101; s_dat[7] = 8'hFF; s_len[7] = 2'd0;
    do_upd();
    host_rd(2'd0, 8'h87, 8'h00, "R3 ch7");
    host_rd(2'd1, 8'h05, 8'h00, "R6 break change");
    host_wr(8'hA5, 8'h80, "R9 push on non-tx context");
    host_rd(2'd3, 8'h1F, 8'h80, "R8 five bit data");
    @(negedge clk);
    s_len[7] = 2'd3;
    host_rd(2'd3, 8'hFF, 8'h80, "R8 eight bit data");
    host_rd(2'd3, 8'hFF, 8'h80, "R8 eight bit data again");

    @(negedge clk);
    s_evt[7] = 0;
    chk_irq(1'b0, "R10 all quiet");
    do_upd();
    host_rd(2'd0, 8'h00, 8'h00, "R3 no request");
    host_rd(2'd1, 8'h00, 8'h00, "R6 no type");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule